// File: doc/BRIEF.md
# GPIO serial configuration loader

This block holds a 13-bit static setting for each of 38 I/O pads and moves those settings out to per-pad shadow registers over two serial shift chains of 19 pads each. Software writes the wanted setting of every pad into a bank of staging registers. It then starts a transfer through one control and status register. Because the pads apply only the shadow copies, a staging write has no visible effect until a load takes place.

An automatic transfer serializes the staging bank into both chains at the same time. It then pulses a single load that updates every shadow in the same cycle, and it reports progress on a busy flag. A second, diagnostic path lets software drive the chain clock, the two serial data lines, the load strobe and an active-low return-to-default directly from register bits. Default settings are parameters, one per pad, and both the staging bank and the shadows take them on system reset.

Top module: `gpio_cfg_loader`

## Requirements
- R1: After system reset every pad output and every staging register holds its parameter default (pads 0 to 18: 0x0403, pads 19 to 37: 0x1808 by default), and the control register (address 0) reads 0x004.
- R2: A write to address 1 to 38 stores into the staging register of pad (address - 1), and a read of that address returns it. A staging write leaves every pad output unchanged.
- R3: The control word has these fields: bit 0 start/busy, bit 1 manual enable, bit 2 reset-bar, bit 3 load, bit 4 chain clock, bit 5 serial line for pads 19 to 37, bit 6 serial line for pads 0 to 18. Reads return bits 6:1 as last written, and bit 0 returns the busy state.
- R4: A control write with bit 0 = 1 and bit 1 = 0 while idle starts a transfer. Busy reads 1 from the next cycle, for exactly 495 cycles, which is 247 chain shifts at one every two clocks plus a one-cycle load. In the cycle where busy drops, every pad output equals its staging value.
- R5: A start request made while busy is ignored. The running transfer ends at its original time.
- R6: A start request with bit 1 = 1 is ignored.
- R7: With bit 1 = 1, each 0-to-1 change of bit 4 shifts both chains once, one cycle after the write. Bit 6 enters the pads 0 to 18 chain and bit 5 enters the pads 19 to 37 chain. After 247 shifts, the first bit shifted on the low chain lands in pad 18 bit 12 and the last lands in pad 0 bit 0. On the high chain, the first bit lands in pad 19 bit 12 and the last lands in pad 37 bit 0.
- R8: With bit 1 = 1, each 0-to-1 change of bit 3 copies both chains into all 38 pad outputs at once, one cycle after the write. Chain shifts alone never change the pad outputs.
- R9: Holding bit 4 at 1 across several writes shifts only once, and holding bit 3 at 1 loads only once.
- R10: While bit 2 is 0, every pad output is forced to its default from the cycle after the write. Setting bit 2 back to 1 does not restore the earlier settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 6 | Write address: 0 control, 1 to 38 staging |
| wrData | input | 13 | Write data |
| rdAddr | input | 6 | Read address, same map as writes |
| rdData | output | 13 | Combinational read data; unmapped addresses read 0 |
| padCfg | output | 494 | Applied setting per pad, pad p at bits [13p+12:13p] |

## Verification
The hardest situation to reach from the ports is a fully known chain image arriving through the manual path. Every bit position of both chains must be set, and the reversed ordering must be observed in the pad outputs. The stimulus drives 247 complete clock cycles of writes with two distinct bit streams, one per chain, then issues one load. The bench compares all 38 pads against a behavioural bit-array model on every clock. The timing of the automatic transfer is covered the same way: a start is retried mid-transfer, and the bench checks that busy drops in exactly the modelled cycle.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;
  // Strobes from the control section to the datapath
  typedef struct packed {
    logic shiftEn;   // advance both chains by one bit
    logic loadEn;    // copy both chains into all pad shadows
    logic holdDflt;  // force pad shadows to their defaults
    logic autoSel;   // serial data comes from the staging image
    logic dinLo;     // manual serial bit for pads 0..HALF-1
    logic dinHi;     // manual serial bit for pads HALF..NUM_PADS-1
  } cfg_strobe_t;
endpackage

// File: rtl/cfgload_ctrl.sv
module cfgload_ctrl
  import cfgload_pkg::*;
#(
  parameter int NUM_PADS = 38,
  parameter int CFG_W    = 13
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [$clog2(NUM_PADS+1)-1:0]    wrAddr,
  input  logic [CFG_W-1:0]                 wrData,
  output cfg_strobe_t                      strb,
  output logic [$clog2((NUM_PADS/2)*CFG_W)-1:0] seqIdx,
  output logic [CFG_W-1:0]                 ctrlWord
);
  localparam int HALF = NUM_PADS / 2;
  localparam int CLEN = HALF * CFG_W;
  localparam int IDXW = $clog2(CLEN);

  logic busy, phase, loadPh;
  logic bbEn, bbRstN, bbLoad, bbClk, bbD1, bbD2;
  logic bbClkQ, bbLoadQ;
  logic ctrlWr, startReq;

  assign ctrlWr   = wrEn && (wrAddr == '0);
  assign startReq = ctrlWr && wrData[0] && !wrData[1] && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      phase   <= 1'b0;
      loadPh  <= 1'b0;
      seqIdx  <= '0;
      bbEn    <= 1'b0;
      bbRstN  <= 1'b1;
      bbLoad  <= 1'b0;
      bbClk   <= 1'b0;
      bbD1    <= 1'b0;
      bbD2    <= 1'b0;
      bbClkQ  <= 1'b0;
      bbLoadQ <= 1'b0;
    end else begin
      bbClkQ  <= bbClk;
      bbLoadQ <= bbLoad;
      if (busy) begin
        if (loadPh) begin
          busy   <= 1'b0;
          loadPh <= 1'b0;
        end else begin
          phase <= ~phase;
          if (phase) begin
            if (seqIdx == '0) loadPh <= 1'b1;
            else              seqIdx <= seqIdx - 1'b1;
          end
        end
      end
      if (ctrlWr) begin
        bbEn   <= wrData[1];
        bbRstN <= wrData[2];
        bbLoad <= wrData[3];
        bbClk  <= wrData[4];
        bbD1   <= wrData[5];
        bbD2   <= wrData[6];
      end
      if (startReq) begin
        busy   <= 1'b1;
        phase  <= 1'b0;
        loadPh <= 1'b0;
        seqIdx <= IDXW'(CLEN - 1);
      end
    end
  end

  always_comb begin
    strb.autoSel  = busy;
    strb.shiftEn  = (busy && phase && !loadPh) ||
                    (bbEn && bbClk && !bbClkQ && !busy);
    strb.loadEn   = (busy && loadPh) ||
                    (bbEn && bbLoad && !bbLoadQ && !busy);
    strb.holdDflt = !bbRstN;
    strb.dinLo    = bbD2;
    strb.dinHi    = bbD1;
    ctrlWord      = '0;
    ctrlWord[6:0] = {bbD2, bbD1, bbClk, bbLoad, bbRstN, bbEn, busy};
  end
endmodule

// File: rtl/cfgload_data.sv
module cfgload_data
  import cfgload_pkg::*;
#(
  parameter int NUM_PADS = 38,
  parameter int CFG_W    = 13,
  parameter logic [NUM_PADS*CFG_W-1:0] PAD_DEFAULTS = '0
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [$clog2(NUM_PADS+1)-1:0]    wrAddr,
  input  logic [CFG_W-1:0]                 wrData,
  input  logic [$clog2(NUM_PADS+1)-1:0]    rdAddr,
  input  logic [CFG_W-1:0]                 ctrlWord,
  input  cfg_strobe_t                      strb,
  input  logic [$clog2((NUM_PADS/2)*CFG_W)-1:0] seqIdx,
  output logic [CFG_W-1:0]                 rdData,
  output logic [NUM_PADS*CFG_W-1:0]        padCfg
);
  localparam int HALF = NUM_PADS / 2;
  localparam int CLEN = HALF * CFG_W;

  logic [CFG_W-1:0] stage  [NUM_PADS];
  logic [CFG_W-1:0] shadow [NUM_PADS];
  logic [CLEN-1:0]  chainLo, chainHi, imgLo, imgHi;
  logic             dinLo, dinHi;

  // Staging image laid out in final chain positions
  always_comb begin
    imgLo = '0;
    imgHi = '0;
    for (int p = 0; p < HALF; p++) begin
      for (int b = 0; b < CFG_W; b++) begin
        imgLo[p*CFG_W + b]            = stage[p][b];
        imgHi[(HALF-1-p)*CFG_W + b]   = stage[HALF+p][b];
      end
    end
  end

  assign dinLo = strb.autoSel ? imgLo[seqIdx] : strb.dinLo;
  assign dinHi = strb.autoSel ? imgHi[seqIdx] : strb.dinHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainLo <= '0;
      chainHi <= '0;
      for (int p = 0; p < NUM_PADS; p++) begin
        stage[p]  <= PAD_DEFAULTS[p*CFG_W +: CFG_W];
        shadow[p] <= PAD_DEFAULTS[p*CFG_W +: CFG_W];
      end
    end else begin
      for (int p = 0; p < NUM_PADS; p++)
        if (wrEn && (int'(wrAddr) == p + 1)) stage[p] <= wrData;
      if (strb.shiftEn) begin
        chainLo <= {chainLo[CLEN-2:0], dinLo};
        chainHi <= {chainHi[CLEN-2:0], dinHi};
      end
      if (strb.holdDflt) begin
        for (int p = 0; p < NUM_PADS; p++)
          shadow[p] <= PAD_DEFAULTS[p*CFG_W +: CFG_W];
      end else if (strb.loadEn) begin
        for (int p = 0; p < HALF; p++) begin
          shadow[p]      <= chainLo[p*CFG_W +: CFG_W];
          shadow[HALF+p] <= chainHi[(HALF-1-p)*CFG_W +: CFG_W];
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == '0) rdData = ctrlWord;
    for (int p = 0; p < NUM_PADS; p++)
      if (int'(rdAddr) == p + 1) rdData = stage[p];
  end

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
    assign padCfg[g*CFG_W +: CFG_W] = shadow[g];
  end
endmodule

// File: rtl/gpio_cfg_loader.sv
module gpio_cfg_loader
  import cfgload_pkg::*;
#(
  parameter int NUM_PADS = 38,
  parameter int CFG_W    = 13,
  parameter logic [NUM_PADS*CFG_W-1:0] PAD_DEFAULTS =
    {{(NUM_PADS - NUM_PADS/2){13'h1808}}, {(NUM_PADS/2){13'h0403}}}
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [$clog2(NUM_PADS+1)-1:0] wrAddr,
  input  logic [CFG_W-1:0]              wrData,
  input  logic [$clog2(NUM_PADS+1)-1:0] rdAddr,
  output logic [CFG_W-1:0]              rdData,
  output logic [NUM_PADS*CFG_W-1:0]     padCfg
);
  localparam int IDXW = $clog2((NUM_PADS/2)*CFG_W);

  cfg_strobe_t      strb;
  logic [IDXW-1:0]  seqIdx;
  logic [CFG_W-1:0] ctrlWord;

  cfgload_ctrl #(.NUM_PADS(NUM_PADS), .CFG_W(CFG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .seqIdx(seqIdx), .ctrlWord(ctrlWord)
  );

  cfgload_data #(.NUM_PADS(NUM_PADS), .CFG_W(CFG_W),
                 .PAD_DEFAULTS(PAD_DEFAULTS)) u_data (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .ctrlWord(ctrlWord), .strb(strb), .seqIdx(seqIdx),
    .rdData(rdData), .padCfg(padCfg)
  );
endmodule

// File: rtl/cfgload_chk.sv
module cfgload_chk
  import cfgload_pkg::*;
#(
  parameter int NUM_PADS = 38,
  parameter int CFG_W    = 13,
  parameter logic [NUM_PADS*CFG_W-1:0] PAD_DEFAULTS = '0
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          wrEn,
  input logic [$clog2(NUM_PADS+1)-1:0] wrAddr,
  input logic [CFG_W-1:0]              wrData,
  input logic [NUM_PADS*CFG_W-1:0]     padCfg,
  input cfg_strobe_t                   strb
);
  // R2
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadEn && !strb.holdDflt) |=> $stable(padCfg));

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == '0 && wrData[0] && !wrData[1] && !strb.autoSel)
      |=> strb.autoSel);

  // R4
  end_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.autoSel) |-> $past(strb.loadEn));

  // R4
  shift_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.autoSel && strb.shiftEn) |=> !strb.shiftEn);

  // R8
  shift_load_apart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.autoSel |-> !(strb.shiftEn && strb.loadEn));

  // R10
  default_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.holdDflt |=> (padCfg == PAD_DEFAULTS));
endmodule

bind gpio_cfg_loader cfgload_chk #(
  .NUM_PADS(NUM_PADS), .CFG_W(CFG_W), .PAD_DEFAULTS(PAD_DEFAULTS)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .padCfg(padCfg), .strb(strb)
);

// File: tb/tb_gpio_cfg_loader.sv
module tb_gpio_cfg_loader;
  localparam int NP = 38;
  localparam int CW = 13;
  localparam int HP = 19;
  localparam int CL = 247;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [5:0]        wrAddr = '0;
  logic [CW-1:0]     wrData = '0;
  logic [5:0]        rdAddr = '0;
  logic [CW-1:0]     rdData;
  logic [NP*CW-1:0]  padCfg;

  int total = 0;
  int bad = 0;
  string curReq = "R1";
  bit done = 0;

  gpio_cfg_loader dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .padCfg(padCfg)
  );

  always #4 clk = ~clk;

  // ---------------- reference model ----------------
  logic [CW-1:0] mStage [NP];
  logic [CW-1:0] mShadow[NP];
  logic [CW-1:0] mSnap  [NP];
  bit mLo[CL];
  bit mHi[CL];
  int mRem;
  bit mEn, mRst, mLd, mCk, mD1, mD2, mCkQ, mLdQ;

  function automatic logic [CW-1:0] dfltOf(int p);
    return (p < HP) ? 13'h0403 : 13'h1808;
  endfunction

  function automatic logic [CW-1:0] stagePat(int p);
    return CW'((p * 611 + 165) & 13'h1fff);
  endfunction

  function automatic bit loBit(int n);
    return ((n * 7 + 3) % 5) < 2;
  endfunction

  function automatic bit hiBit(int n);
    return ((n * 11 + 1) % 3) == 0;
  endfunction

  task automatic modelReset();
    for (int p = 0; p < NP; p++) begin
      mStage[p] = dfltOf(p); mShadow[p] = dfltOf(p); mSnap[p] = dfltOf(p);
    end
    for (int k = 0; k < CL; k++) begin mLo[k] = 0; mHi[k] = 0; end
    mRem = 0; mEn = 0; mRst = 1; mLd = 0; mCk = 0; mD1 = 0; mD2 = 0;
    mCkQ = 0; mLdQ = 0;
  endtask

  task automatic modelStep();
    bit doShift, doLoad, autoDone, idle;
    idle    = (mRem == 0);
    doShift = mEn && mCk && !mCkQ && idle;
    doLoad  = mEn && mLd && !mLdQ && idle;
    autoDone = 0;
    if (mRem > 0) begin
      mRem--;
      if (mRem == 0) begin
        autoDone = 1;
        for (int p = 0; p < HP; p++)
          for (int b = 0; b < CW; b++) begin
            mLo[p*CW + b]        = mSnap[p][b];
            mHi[(HP-1-p)*CW + b] = mSnap[HP+p][b];
          end
      end
    end
    if (!mRst) begin
      for (int p = 0; p < NP; p++) mShadow[p] = dfltOf(p);
    end else if (doLoad || autoDone) begin
      for (int p = 0; p < HP; p++)
        for (int b = 0; b < CW; b++) begin
          mShadow[p][b]    = mLo[p*CW + b];
          mShadow[HP+p][b] = mHi[(HP-1-p)*CW + b];
        end
    end
    if (doShift) begin
      for (int k = CL - 1; k > 0; k--) begin
        mLo[k] = mLo[k-1];
        mHi[k] = mHi[k-1];
      end
      mLo[0] = mD2;
      mHi[0] = mD1;
    end
    mCkQ = mCk;
    mLdQ = mLd;
    if (wrEn && wrAddr >= 1 && wrAddr <= NP) mStage[wrAddr-1] = wrData;
    if (wrEn && wrAddr == 0) begin
      mEn = wrData[1]; mRst = wrData[2]; mLd = wrData[3];
      mCk = wrData[4]; mD1 = wrData[5]; mD2 = wrData[6];
      if (wrData[0] && !wrData[1] && idle) begin
        mRem = 495;
        for (int p = 0; p < NP; p++) mSnap[p] = mStage[p];
      end
    end
  endtask

  function automatic logic [NP*CW-1:0] packShadow();
    logic [NP*CW-1:0] v;
    for (int p = 0; p < NP; p++) v[p*CW +: CW] = mShadow[p];
    return v;
  endfunction

  function automatic logic [CW-1:0] expRead();
    logic [CW-1:0] v;
    v = '0;
    if (rdAddr == 0) v[6:0] = {mD2, mD1, mCk, mLd, mRst, mEn, bit'(mRem > 0)};
    else if (rdAddr <= NP) v = mStage[rdAddr-1];
    return v;
  endfunction

  task automatic chk(string req, logic [NP*CW-1:0] act, logic [NP*CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model update and full comparison on every clock
  initial modelReset();
  always @(posedge clk) begin
    if (!rstN) modelReset();
    else       modelStep();
    #2;
    if (rstN && !done) begin
      chk({curReq, " pads"}, padCfg, packShadow());
      chk({curReq, " read"}, {{(NP*CW-CW){1'b0}}, rdData},
          {{(NP*CW-CW){1'b0}}, expRead()});
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 6'(a); wrData = CW'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idleN(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [CW-1:0] padOf(int p);
    return padCfg[p*CW +: CW];
  endfunction

  initial begin
    int ctl;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idleN(2);

    // R1: reset state
    curReq = "R1";
    rdAddr = 0; #1;
    chk("R1 ctrl", NP*CW'(rdData), NP*CW'(13'h004));
    chk("R1 pad0", NP*CW'(padOf(0)), NP*CW'(13'h0403));
    chk("R1 pad37", NP*CW'(padOf(37)), NP*CW'(13'h1808));
    rdAddr = 20; #1;
    chk("R1 stage19", NP*CW'(rdData), NP*CW'(13'h1808));

    // R2: staging writes do not reach pads
    curReq = "R2";
    for (int p = 0; p < NP; p++) wr(p + 1, stagePat(p));
    for (int p = 0; p < NP; p += 9) begin
      @(negedge clk); rdAddr = 6'(p + 1); #1;
      chk("R2 readback", NP*CW'(rdData), NP*CW'(stagePat(p)));
    end
    chk("R2 pads unchanged", NP*CW'(padOf(5)), NP*CW'(13'h0403));

    // R4: automatic transfer
    curReq = "R4";
    @(negedge clk); rdAddr = 0;
    wr(0, 13'h005);
    chk("R4 busy set", NP*CW'(rdData[0]), NP*CW'(1));
    chk("R3 start self-clear", NP*CW'(rdData[6:1]), NP*CW'(6'b000010));
    idleN(150);
    // R5: retry while busy
    curReq = "R5";
    wr(0, 13'h005);
    idleN(200);
    curReq = "R4";
    idleN(200);
    chk("R4 busy clear", NP*CW'(rdData[0]), NP*CW'(0));
    chk("R4 pad0", NP*CW'(padOf(0)), NP*CW'(stagePat(0)));
    chk("R4 pad18", NP*CW'(padOf(18)), NP*CW'(stagePat(18)));
    chk("R4 pad19", NP*CW'(padOf(19)), NP*CW'(stagePat(19)));
    chk("R4 pad37", NP*CW'(padOf(37)), NP*CW'(stagePat(37)));

    // R6: start with manual enable is ignored
    curReq = "R6";
    wr(0, 13'h007);
    chk("R6 no busy", NP*CW'(rdData[0]), NP*CW'(0));

    // R7: manual shifting of two distinct streams
    curReq = "R7";
    for (int n = 0; n < CL; n++) begin
      ctl = 13'h006 | (int'(hiBit(n)) << 5) | (int'(loBit(n)) << 6);
      wr(0, ctl);
      wr(0, ctl | 13'h010);
    end
    chk("R8 shift alone keeps pads", NP*CW'(padOf(0)), NP*CW'(stagePat(0)));
    curReq = "R8";
    wr(0, 13'h00e);
    idleN(1);
    chk("R7 pad18 bit12", NP*CW'(padOf(18)[12]), NP*CW'(loBit(0)));
    chk("R7 pad0 bit0", NP*CW'(padOf(0)[0]), NP*CW'(loBit(CL-1)));
    chk("R7 pad19 bit12", NP*CW'(padOf(19)[12]), NP*CW'(hiBit(0)));
    chk("R7 pad37 bit0", NP*CW'(padOf(37)[0]), NP*CW'(hiBit(CL-1)));

    // R9: held clock and held load act once
    curReq = "R9";
    wr(0, 13'h046);
    wr(0, 13'h056);
    wr(0, 13'h056);
    wr(0, 13'h016);
    wr(0, 13'h01e);
    wr(0, 13'h01e);
    wr(0, 13'h006);
    idleN(2);

    // R10: return to defaults
    curReq = "R10";
    wr(0, 13'h002);
    idleN(1);
    chk("R10 pad3 default", NP*CW'(padOf(3)), NP*CW'(13'h0403));
    chk("R10 pad30 default", NP*CW'(padOf(30)), NP*CW'(13'h1808));
    wr(0, 13'h006);
    idleN(2);
    chk("R10 stays default", NP*CW'(padOf(30)), NP*CW'(13'h1808));

    // R4: second automatic transfer restores staging
    curReq = "R4";
    wr(0, 13'h005);
    idleN(500);
    chk("R4 reapply pad30", NP*CW'(padOf(30)), NP*CW'(stagePat(30)));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog %s actual=hung expected=finished", curReq);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule